// File: doc/BRIEF.md
# Partitioned RAM Pattern Self-Test Sequencer

This block is a built-in self-test controller for a single-port RAM that must be precharged before every access. After a start pulse it first clears every word to zero. It then divides the address space into two interleaved halves, chosen by one address bit. That bit moves from the top address bit down to bit 3, one pass for each bit. In every pass it runs a fixed table of eight steps. Each step fills one half with all-ones or all-zeros and then reads back the other half against an expected pattern. This exposes coupling between cells whose addresses differ in the selected bit.

Each access takes four clock cycles: a one-cycle precharge pulse, a recovery cycle, a one-cycle access strobe with a write or read qualifier, and a closing cycle. The closing cycle of one access is also the cycle in which the next one is issued. Every read is compared, and any mismatch sets a fail flag that stays set. When the last read has been checked the controller raises done and waits for the next start.

Top module: `mbist_seq`

## Requirements
- R1: While reset is high and afterwards until start, `done` and `fail` are 0, `ram_pre_n` is 1 and `ram_acc`, `ram_wr`, `ram_rd` are 0. No access happens before a start pulse.
- R2: Every access is four cycles long. `ram_pre_n` is low for exactly one cycle and high in the next. `ram_acc` is high for exactly one cycle, with exactly one of `ram_wr`/`ram_rd`. In the cycle after that, all three are low. `ram_addr` holds steady from the precharge cycle through the access cycle. `ram_wr`/`ram_rd` are never high without `ram_acc`.
- R3: The first MEM_SIZE accesses after start are writes of zero to addresses 0, 1, ..., MEM_SIZE-1, in ascending order.
- R4: Then the passes follow, with stride values MEM_SIZE/2, MEM_SIZE/4, ..., down to and including 8. The upper half of a pass is the set of addresses with (address AND stride) nonzero. The lower half is the rest.
- R5: Each pass runs steps 0..7. The half written in each step is, for steps 0..7: upper, upper, lower, upper, lower, lower, upper, lower. After the write, the opposite half is read.
- R6: Each half is visited in ascending address order. The write data for steps 0..7 is ones,zeros,ones,ones,zeros,ones,zeros,zeros. The expected read data is zeros,zeros,zeros,ones,ones,ones,ones,zeros.
- R7: "Ones" means all DATA_W bits of `ram_wdata` are 1. "Zeros" means all are 0. Write data never takes any other value.
- R8: The RAM returns read data on `ram_rdata` in the cycle after the access strobe, and the controller compares it there. Any mismatch sets `fail`, which holds until the next accepted start clears it.
- R9: `done` rises exactly 4·N+2 clock edges after the edge that samples start, counting that edge, where N is the total number of accesses. It then stays high with the RAM port idle until the next start.
- R10: A start pulse while the test is running is ignored, and the access sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| done | output | 1 | Test complete, held until next start |
| fail | output | 1 | Sticky read-mismatch flag |
| ram_pre_n | output | 1 | Active-low precharge pulse |
| ram_acc | output | 1 | Access strobe |
| ram_wr | output | 1 | Write qualifier |
| ram_rd | output | 1 | Read qualifier |
| ram_addr | output | $clog2(MEM_SIZE) | Word address |
| ram_wdata | output | DATA_W | Write data |
| ram_rdata | input | DATA_W | Read data, valid the cycle after the strobe |

## Verification
The bench builds the full expected access list by filtering ascending addresses on the stride bit, not by stepping a wrap counter. A walk that wraps one word too early or too late, or adds the stride in the wrong mode, therefore shows up as a wrong address in a specific step. The RAM model starts full of garbage, so a missing clear phase makes reads mismatch. Injected single-bit read faults, including the top bit of the last word, must raise fail. A following clean run must clear it, which catches a flag that is not sticky or is never reset. Stray start pulses during a run would disturb the access list if they were honoured. The exact done cycle catches any extra or missing idle cycle between accesses.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_REL,
    PH_ACC,
    PH_END
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_RUN
  } seq_e;

  // bit i belongs to step i
  localparam logic [7:0] WR_UPPER = 8'b0100_1011;
  localparam logic [7:0] WR_ONES  = 8'b0010_1101;
  localparam logic [7:0] RD_ONES  = 8'b0111_1000;

endpackage

// File: rtl/mbist_half_walk.sv
module mbist_half_walk #(
  parameter int MEM_SIZE = 64,
  parameter int AW       = $clog2(MEM_SIZE)
) (
  input  logic [AW:0] cur,
  input  logic [AW:0] stride,
  input  logic        upper,
  output logic [AW:0] nxt,
  output logic        last
);
  localparam logic [AW:0] SIZE_W = (AW+1)'(MEM_SIZE);

  logic [AW:0] inc;
  logic [AW:0] span_mask;
  logic [AW:0] low;

  always_comb begin
    inc       = cur + 1'b1;
    span_mask = (stride << 1) - 1'b1;
    low       = inc & span_mask;
    nxt       = inc;
    if (upper && (low == '0))
      nxt = inc + stride;
    else if (!upper && (low == stride))
      nxt = inc + stride;
    last = (nxt >= SIZE_W);
  end

endmodule

// File: rtl/mbist_access_port.sv
module mbist_access_port
  import mbist_pkg::*;
#(
  parameter int AW     = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_wr,
  input  logic [AW-1:0]     go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  input  logic [DATA_W-1:0] go_exp,
  output logic              ready,
  output logic              fin,
  output logic              miss,
  output logic              ram_pre_n,
  output logic              ram_acc,
  output logic              ram_wr,
  output logic              ram_rd,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  phase_e            ph;
  logic              op_wr;
  logic [DATA_W-1:0] exp_q;

  assign ready = (ph == PH_IDLE) || (ph == PH_END);
  assign fin   = (ph == PH_END);
  assign miss  = fin && !op_wr && (ram_rdata != exp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      ram_pre_n <= 1'b1;
      ram_acc   <= 1'b0;
      ram_wr    <= 1'b0;
      ram_rd    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      op_wr     <= 1'b0;
      exp_q     <= '0;
    end else begin
      ram_pre_n <= 1'b1;
      ram_acc   <= 1'b0;
      ram_wr    <= 1'b0;
      ram_rd    <= 1'b0;
      case (ph)
        PH_IDLE, PH_END: begin
          if (go) begin
            ph        <= PH_PRE;
            ram_pre_n <= 1'b0;
            ram_addr  <= go_addr;
            ram_wdata <= go_wr ? go_wdata : '0;
            op_wr     <= go_wr;
            exp_q     <= go_exp;
          end else begin
            ph <= PH_IDLE;
          end
        end
        PH_PRE: ph <= PH_REL;
        PH_REL: begin
          ph      <= PH_ACC;
          ram_acc <= 1'b1;
          ram_wr  <= op_wr;
          ram_rd  <= !op_wr;
        end
        PH_ACC:  ph <= PH_END;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_PRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !ram_pre_n |=> ram_pre_n); // R2
  AST_ACC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ram_acc |=> !ram_acc); // R2
  AST_ACC_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_acc) |-> ($past(ram_pre_n) && !$past(ram_pre_n, 2))); // R2
  AST_ONE_QUALIFIER: assert property (@(posedge clk) disable iff (rst)
    ram_acc |-> (ram_wr ^ ram_rd)); // R2
  AST_NO_BARE_QUAL: assert property (@(posedge clk) disable iff (rst)
    !ram_acc |-> (!ram_wr && !ram_rd)); // R2
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
    ram_acc |-> $stable(ram_addr)); // R2

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int MEM_SIZE = 64,
  parameter int DATA_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  output logic                        done,
  output logic                        fail,
  output logic                        ram_pre_n,
  output logic                        ram_acc,
  output logic                        ram_wr,
  output logic                        ram_rd,
  output logic [$clog2(MEM_SIZE)-1:0] ram_addr,
  output logic [DATA_W-1:0]           ram_wdata,
  input  logic [DATA_W-1:0]           ram_rdata
);
  localparam int          AW         = $clog2(MEM_SIZE);
  localparam logic [AW:0] HALF       = (AW+1)'(MEM_SIZE / 2);
  localparam logic [AW:0] LAST_WORD  = (AW+1)'(MEM_SIZE - 1);
  localparam logic [AW:0] MIN_STRIDE = (AW+1)'(8);
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  seq_e        st;
  logic [AW:0] cur;
  logic [AW:0] stride;
  logic [2:0]  step;
  logic [2:0]  step_nx;
  logic        rd_half;
  logic        all_issued;

  logic        upper;
  logic [AW:0] walk_nxt;
  logic        walk_last;
  logic        go, ready, fin, miss;
  logic        go_wr;
  logic [DATA_W-1:0] go_wdata, go_exp;

  assign step_nx  = step + 3'd1;
  assign upper    = WR_UPPER[step] ^ rd_half;
  assign go       = (st != ST_IDLE) && ready && !all_issued;
  assign go_wr    = (st == ST_CLEAR) || !rd_half;
  assign go_wdata = ((st == ST_RUN) && WR_ONES[step]) ? ONES : '0;
  assign go_exp   = RD_ONES[step] ? ONES : '0;

  mbist_half_walk #(.MEM_SIZE(MEM_SIZE), .AW(AW)) u_walk (
    .cur    (cur),
    .stride (stride),
    .upper  (upper),
    .nxt    (walk_nxt),
    .last   (walk_last)
  );

  mbist_access_port #(.AW(AW), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_wr     (go_wr),
    .go_addr   (cur[AW-1:0]),
    .go_wdata  (go_wdata),
    .go_exp    (go_exp),
    .ready     (ready),
    .fin       (fin),
    .miss      (miss),
    .ram_pre_n (ram_pre_n),
    .ram_acc   (ram_acc),
    .ram_wr    (ram_wr),
    .ram_rd    (ram_rd),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur        <= '0;
      stride     <= HALF;
      step       <= '0;
      rd_half    <= 1'b0;
      all_issued <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else if (st == ST_IDLE) begin
      if (start) begin
        st         <= ST_CLEAR;
        cur        <= '0;
        stride     <= HALF;
        step       <= '0;
        rd_half    <= 1'b0;
        all_issued <= 1'b0;
        done       <= 1'b0;
        fail       <= 1'b0;
      end
    end else begin
      if (miss) fail <= 1'b1;
      if (fin && all_issued) begin
        st         <= ST_IDLE;
        done       <= 1'b1;
        all_issued <= 1'b0;
      end
      if (go) begin
        if (st == ST_CLEAR) begin
          if (cur == LAST_WORD) begin
            st      <= ST_RUN;
            stride  <= HALF;
            step    <= '0;
            rd_half <= 1'b0;
            cur     <= WR_UPPER[0] ? HALF : '0;
          end else begin
            cur <= cur + 1'b1;
          end
        end else if (!walk_last) begin
          cur <= walk_nxt;
        end else if (!rd_half) begin
          rd_half <= 1'b1;
          cur     <= WR_UPPER[step] ? '0 : stride;
        end else if (step != 3'd7) begin
          step    <= step_nx;
          rd_half <= 1'b0;
          cur     <= WR_UPPER[step_nx] ? stride : '0;
        end else if (stride != MIN_STRIDE) begin
          stride  <= stride >> 1;
          step    <= '0;
          rd_half <= 1'b0;
          cur     <= WR_UPPER[0] ? (stride >> 1) : '0;
        end else begin
          all_issued <= 1'b1;
        end
      end
    end
  end

  AST_WDATA_FLAT: assert property (@(posedge clk) disable iff (rst)
    ram_wr |-> ((ram_wdata == '0) || (ram_wdata == ONES))); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (ram_pre_n && !ram_acc)); // R9
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (ram_acc && start) |=> !done); // R10

endmodule

// File: tb/mbist_seq_tb.sv
module mbist_seq_tb;
  localparam int S    = 64;
  localparam int DW   = 8;
  localparam int AW   = $clog2(S);
  localparam int NACC = S * (1 + 8 * (AW - 3));
  localparam logic [DW-1:0] ONES = {DW{1'b1}};
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done, fail;
  logic ram_pre_n, ram_acc, ram_wr, ram_rd;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;

  always #4 clk = ~clk;

  mbist_seq #(.MEM_SIZE(S), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
    .ram_pre_n(ram_pre_n), .ram_acc(ram_acc), .ram_wr(ram_wr), .ram_rd(ram_rd),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // expected access list
  int            e_addr [NACC];
  bit            e_wr   [NACC];
  logic [DW-1:0] e_dat  [NACC];
  bit tb_up [8] = '{1,1,0,1,0,0,1,0};
  bit tb_wd [8] = '{1,0,1,1,0,1,0,0};
  bit tb_rd [8] = '{0,0,0,1,1,1,1,0};

  // RAM model with read fault injection
  logic [DW-1:0] mem [S];
  bit            scramble = 0;
  int            scr_seed = 0;
  bit            fault_on = 0;
  int            fault_addr = 0;
  logic [DW-1:0] fault_mask = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (scramble) begin
      for (int i = 0; i < S; i++) mem[i] <= DW'(i * 37 + scr_seed);
    end else begin
      if (ram_acc && ram_wr) mem[ram_addr] <= ram_wdata;
      if (ram_acc && ram_rd)
        ram_rdata <= mem[ram_addr] ^ ((fault_on && int'(ram_addr) == fault_addr) ? fault_mask : '0);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // access monitor
  bit mon_on = 0;
  int idx = 0;
  logic p1 = 1'b1, p2 = 1'b1;

  always @(negedge clk) begin
    if (!rst && ram_acc) begin
      chk(p1 === 1'b1 && p2 === 1'b0, "R2", "precharge then recovery before strobe", {p2, p1}, 1);
      if (!mon_on || idx >= NACC) begin
        chk(0, "R9", "access outside expected sequence", idx, NACC);
      end else begin
        chk(int'(ram_addr) == e_addr[idx], idx < S ? "R3" : "R4/R5", "address", int'(ram_addr), e_addr[idx]);
        chk(ram_wr == e_wr[idx], "R5", "direction write", ram_wr, e_wr[idx]);
        if (e_wr[idx])
          chk(ram_wdata == e_dat[idx], "R6 R7", "write data", ram_wdata, e_dat[idx]);
        idx++;
      end
    end
    p2 = p1;
    p1 = ram_pre_n;
  end

  always @(posedge clk) begin
    if (cyc == LIMIT && !finished) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic build_list();
    int n = 0;
    for (int a = 0; a < S; a++) begin
      e_addr[n] = a; e_wr[n] = 1; e_dat[n] = '0; n++;
    end
    for (int sd = S / 2; sd >= 8; sd = sd / 2) begin
      for (int s = 0; s < 8; s++) begin
        for (int a = 0; a < S; a++)
          if (((a & sd) != 0) == tb_up[s]) begin
            e_addr[n] = a; e_wr[n] = 1; e_dat[n] = tb_wd[s] ? ONES : '0; n++;
          end
        for (int a = 0; a < S; a++)
          if (((a & sd) != 0) != tb_up[s]) begin
            e_addr[n] = a; e_wr[n] = 0; e_dat[n] = tb_rd[s] ? ONES : '0; n++;
          end
      end
    end
  endtask

  task automatic run_test(input bit flt, input int faddr, input int fbit, input bit noisy);
    int c0;
    int wait_cyc;
    fault_on   = flt;
    fault_addr = faddr;
    fault_mask = DW'(1) << fbit;
    scr_seed   = int'($urandom % 256);
    @(negedge clk) scramble = 1;
    @(negedge clk) scramble = 0;
    idx = 0;
    mon_on = 1;
    @(negedge clk);
    start = 1;
    c0 = cyc;
    @(negedge clk);
    start = 0;
    chk(done == 1'b0, "R9", "done cleared by start", done, 0);
    chk(fail == 1'b0, "R8", "fail cleared by start", fail, 0);
    wait_cyc = 0;
    while (wait_cyc < 8 * NACC) begin
      @(negedge clk);
      if (done) break;
      wait_cyc++;
      start = (noisy && idx < NACC - 2 && ($urandom % 53) == 0); // R10 stray starts
    end
    start = 0;
    chk(done == 1'b1, "R9", "done reached", done, 1);
    chk(cyc - c0 == 4 * NACC + 2, "R9", "edges from start to done", cyc - c0, 4 * NACC + 2);
    chk(idx == NACC, "R10", "access count", idx, NACC);
    chk(fail == flt, "R8", "fail flag after run", fail, flt);
    repeat (6) @(negedge clk);
    chk(done == 1'b1 && fail == flt, "R9", "done and fail held while idle", {done, fail}, {1'b1, flt});
    chk(idx == NACC, "R9", "no access after done", idx, NACC);
    mon_on = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    build_list();
    repeat (3) @(negedge clk);
    chk(done == 0 && fail == 0, "R1", "flags in reset", {done, fail}, 0);
    chk(ram_pre_n == 1 && ram_acc == 0 && ram_wr == 0 && ram_rd == 0, "R1", "RAM port in reset",
        {ram_pre_n, ram_acc, ram_wr, ram_rd}, 4'b1000);
    rst = 0;
    repeat (5) @(negedge clk);
    chk(ram_pre_n == 1 && ram_acc == 0 && idx == 0, "R1", "no access before start", idx, 0);
    // clean run with stray start pulses
    run_test(0, 0, 0, 1);
    // directed corner: top bit of the last word reads wrong
    run_test(1, S - 1, DW - 1, 0);
    // clean run must clear the sticky flag
    run_test(0, 0, 0, 0);
    // random fault, random stray starts
    run_test(1, int'($urandom % S), int'($urandom % DW), 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule